// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte queue behind the data slot of a storage-bus controller's register window. The host pushes bytes in one at a time with a write strobe and pulls them out with a read strobe. A small occupancy state machine, a byte counter and separate read and write pointers track the queue. Each read that takes a byte out of the queue raises a one-cycle interrupt request.

While the controller waits for the bytes of a bus command, a mode input steers host writes away from the queue and into a separate command buffer. That buffer has its own length counter and a read-back index port. A two-bit phase input decides what a consuming read returns. Phase code 00 means the bus is in the data-out direction. In that phase a read still uses up an entry, but it returns zero and flags an error instead of returning the stored byte.

The occupancy state machine has three states. EMPTY means the count is zero. PARTIAL means the count is between 1 and DEPTH-2. AT_LIMIT means the count is DEPTH-1.

The transitions are:
- EMPTY to PARTIAL on an accepted write.
- PARTIAL to EMPTY when the last entry is consumed.
- PARTIAL to AT_LIMIT when an accepted write brings the count to DEPTH-1.
- AT_LIMIT to PARTIAL on a consuming read without a write.
- Any state to EMPTY on flush.

Top module: `pio_xfer_fifo`

## Requirements
- R1: After reset, the count, both pointers, the command length, the read data, the interrupt request, the error flag and the overrun flag are all zero.
- R2: A write with command mode low, no flush and a count below DEPTH-1 stores the byte at the write pointer. It then increments the count and advances the write pointer; the new values are visible after the clock edge.
- R3: The queue accepts at most DEPTH-1 bytes (15 by default). A write at that count is dropped. The overrun flag is high for the following cycle, and the count and pointers are unchanged.
- R4: A write with command mode high stores the byte in the command buffer at index cmd_len and increments cmd_len. The queue count and pointers are unchanged. Once cmd_len reaches CMD_DEPTH, further command writes are dropped. cmd_byte shows the command buffer entry selected by cmd_idx.
- R5: A read with a non-zero count and phase not 00 decrements the count and advances the read pointer. After the edge, rd_data holds the byte that was at the read pointer.
- R6: A read with a non-zero count and phase 00 (data-out) decrements the count and leaves the read pointer in place. After the edge, rd_data is 0 and pio_err is high for one cycle.
- R7: irq is high in the cycle after each consuming read, and only then.
- R8: Whenever the count becomes zero, both pointers return to zero.
- R9: A read with a zero count changes nothing. rd_data keeps its last value, the pointers stay where they are and irq stays low.
- R10: A flush clears the count, both pointers and cmd_len in one cycle. It overrides any read or write strobe in the same cycle.
- R11: A write and a consuming read in the same cycle are both applied. The count is unchanged and both pointers advance. A write together with a read at zero count acts as a write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and the command buffer |
| wr_en | input | 1 | Host write strobe on the data slot |
| wr_data | input | DATA_W | Byte written by the host |
| rd_en | input | 1 | Host read strobe on the data slot |
| rd_data | output | DATA_W | Value returned by the last consuming read |
| cmd_mode | input | 1 | Steers writes into the command buffer |
| phase | input | 2 | Bus phase code; 00 means data-out |
| irq | output | 1 | One-cycle interrupt request per consuming read |
| pio_err | output | 1 | One-cycle flag for a read taken in data-out phase |
| overrun | output | 1 | One-cycle flag for a write dropped at the limit |
| count | output | CNT_W | Bytes held in the queue |
| rd_ptr | output | PTR_W | Queue read pointer |
| wr_ptr | output | PTR_W | Queue write pointer |
| cmd_len | output | CMD_LW | Bytes held in the command buffer |
| cmd_idx | input | CMD_AW | Command buffer read-back index |
| cmd_byte | output | DATA_W | Command buffer entry at cmd_idx |

## Verification
The queue is filled to every level from 1 to 15 with bytes derived from the level and the position, then drained in order. This separates an off-by-one in the pointers from an off-by-one in the count, and it shows whether the pointers return to zero at each drain. A fill to the limit followed by one extra write shows whether the drop point is at 15 or at 16. A read in data-out phase in the middle of a drain shows whether the read pointer is held while the count still drops. Command-mode bursts longer than the buffer, flushes issued together with a read strobe, and combined read-plus-write cycles (with the queue both occupied and empty) separate the steering, saturation, priority and concurrency rules.

// File: rtl/pio_xfer_pkg.sv
package pio_xfer_pkg;
    // Occupancy of the transfer queue.
    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_PARTIAL  = 2'd1,
        ST_AT_LIMIT = 2'd2
    } occ_state_t;
endpackage

// File: rtl/pio_byte_store.sv
module pio_byte_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pio_xfer_fifo.sv
module pio_xfer_fifo
    import pio_xfer_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int CMD_AW   = $clog2(CMD_DEPTH),
    localparam int CMD_LW   = $clog2(CMD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cmd_mode,
    input  logic [1:0]        phase,
    output logic              irq,
    output logic              pio_err,
    output logic              overrun,
    output logic [CNT_W-1:0]  count,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [CMD_LW-1:0] cmd_len,
    input  logic [CMD_AW-1:0] cmd_idx,
    output logic [DATA_W-1:0] cmd_byte
);
    localparam int LIMIT = DEPTH - 1;

    occ_state_t state, state_nx;

    logic              do_wr, do_rd, drop_wr, cmd_wr, data_out;
    logic [CNT_W-1:0]  count_nx, count_d;
    logic [PTR_W-1:0]  rd_ptr_d, wr_ptr_d;
    logic [DATA_W-1:0] fifo_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Strobe qualification
    assign data_out = (phase == 2'b00);
    assign do_wr    = wr_en && !flush && !cmd_mode && (state != ST_AT_LIMIT);
    assign drop_wr  = wr_en && !flush && !cmd_mode && (state == ST_AT_LIMIT);
    assign cmd_wr   = wr_en && !flush && cmd_mode && (cmd_len < CMD_LW'(CMD_DEPTH));
    assign do_rd    = rd_en && !flush && (state != ST_EMPTY);
    assign count_nx = count + CNT_W'(do_wr) - CNT_W'(do_rd);

    // Storage
    pio_byte_store #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo_mem (
        .clk   (clk),
        .we    (do_wr),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (fifo_q)
    );

    pio_byte_store #(.W(DATA_W), .DEPTH(CMD_DEPTH)) u_cmd_mem (
        .clk   (clk),
        .we    (cmd_wr),
        .waddr (cmd_len[CMD_AW-1:0]),
        .wdata (wr_data),
        .raddr (cmd_idx),
        .rdata (cmd_byte)
    );

    // Next state of the occupancy machine
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (do_wr)
                    state_nx = (count_nx == CNT_W'(LIMIT)) ? ST_AT_LIMIT : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (count_nx == '0)
                    state_nx = ST_EMPTY;
                else if (count_nx == CNT_W'(LIMIT))
                    state_nx = ST_AT_LIMIT;
            end
            ST_AT_LIMIT: begin
                if (do_rd && !do_wr)
                    state_nx = (count_nx == '0) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_nx = ST_EMPTY;
        endcase
        if (flush) state_nx = ST_EMPTY;
    end

    // Next count and pointers; a drained queue rewinds both pointers
    always_comb begin
        if (flush || count_nx == '0) begin
            count_d  = '0;
            rd_ptr_d = '0;
            wr_ptr_d = '0;
        end else begin
            count_d  = count_nx;
            rd_ptr_d = (do_rd && !data_out) ? bump(rd_ptr) : rd_ptr;
            wr_ptr_d = do_wr ? bump(wr_ptr) : wr_ptr;
        end
    end

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_EMPTY;
            count   <= '0;
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            cmd_len <= '0;
        end else begin
            state   <= state_nx;
            count   <= count_d;
            rd_ptr  <= rd_ptr_d;
            wr_ptr  <= wr_ptr_d;
            if (flush)
                cmd_len <= '0;
            else if (cmd_wr)
                cmd_len <= cmd_len + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            irq     <= 1'b0;
            pio_err <= 1'b0;
            overrun <= 1'b0;
        end else begin
            irq     <= do_rd;
            pio_err <= do_rd && data_out;
            overrun <= drop_wr;
            if (do_rd)
                rd_data <= data_out ? '0 : fifo_q;
        end
    end
endmodule

// File: rtl/pio_xfer_fifo_chk.sv
module pio_xfer_fifo_chk #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5,
    parameter int PTR_W     = 4,
    parameter int CMD_LW    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              wr_en,
    input logic              rd_en,
    input logic              cmd_mode,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic              pio_err,
    input logic              overrun,
    input logic [CNT_W-1:0]  count,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [CMD_LW-1:0] cmd_len
);
    localparam int LIMIT = DEPTH - 1;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= LIMIT);

    p_overrun_at_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (int'($past(count)) == LIMIT && $past(wr_en) && !$past(cmd_mode)));

    p_cmd_keeps_queue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_mode && !rd_en && !flush) |=> ($stable(count) && $stable(wr_ptr)));

    p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pio_err |-> (rd_data == '0 && irq));

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(rd_en) && $past(count) != '0 && !$past(flush)));

    p_drain_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (rd_ptr == '0 && wr_ptr == '0));

    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && count == '0) |=> (!irq && $stable(rd_data)));

    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && cmd_len == '0 && !irq));
endmodule

bind pio_xfer_fifo pio_xfer_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .PTR_W  (PTR_W),
    .CMD_LW (CMD_LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .cmd_mode (cmd_mode),
    .rd_data  (rd_data),
    .irq      (irq),
    .pio_err  (pio_err),
    .overrun  (overrun),
    .count    (count),
    .rd_ptr   (rd_ptr),
    .wr_ptr   (wr_ptr),
    .cmd_len  (cmd_len)
);

// File: tb/tb_pio_xfer_fifo.sv
module tb_pio_xfer_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       cmd_mode = 1'b0;
    logic [1:0] phase = 2'b01;
    logic       irq, pio_err, overrun;
    logic [4:0] count;
    logic [3:0] rd_ptr, wr_ptr;
    logic [4:0] cmd_len;
    logic [3:0] cmd_idx = '0;
    logic [7:0] cmd_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pio_xfer_fifo dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cmd_mode(cmd_mode), .phase(phase),
        .irq(irq), .pio_err(pio_err), .overrun(overrun), .count(count),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .cmd_len(cmd_len), .cmd_idx(cmd_idx),
        .cmd_byte(cmd_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; applies strobes for one cycle and returns at the next falling edge.
    task automatic step(input logic w, input logic [7:0] d, input logic r, input logic f);
        wr_en = w; wr_data = d; rd_en = r; flush = f;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL timeout: actual 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 rd_ptr", rd_ptr, 0);
        chk("R1 wr_ptr", wr_ptr, 0);
        chk("R1 cmd_len", cmd_len, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 flags", {irq, pio_err, overrun}, 0);

        // Sweep every fill level: R2, R5, R7, R8
        for (int n = 1; n <= 15; n++) begin
            for (int i = 0; i < n; i++) begin
                step(1'b1, 8'((n * 16 + i * 7) & 255), 1'b0, 1'b0);
                chk("R2 count", count, i + 1);
                chk("R2 wr_ptr", wr_ptr, i + 1);
            end
            for (int i = 0; i < n; i++) begin
                step(1'b0, 8'h00, 1'b1, 1'b0);
                chk("R5 rd_data", rd_data, (n * 16 + i * 7) & 255);
                chk("R7 irq", irq, 1);
                chk("R5 count", count, n - i - 1);
                chk("R8 rd_ptr", rd_ptr, (i == n - 1) ? 0 : i + 1);
                chk("R8 wr_ptr", wr_ptr, (i == n - 1) ? 0 : n);
            end
            @(negedge clk);
            chk("R7 irq low when idle", irq, 0);
        end

        // Fill to the limit then overrun: R3
        for (int i = 0; i < 15; i++) step(1'b1, 8'(8'hA0 + i), 1'b0, 1'b0);
        chk("R3 count at limit", count, 15);
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        chk("R3 overrun", overrun, 1);
        chk("R3 count held", count, 15);
        chk("R3 wr_ptr held", wr_ptr, 15);
        @(negedge clk);
        chk("R3 overrun one cycle", overrun, 0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R3 first byte intact", rd_data, 8'hA0);
        chk("R5 rd_ptr", rd_ptr, 1);

        // Data-out read: R6
        phase = 2'b00;
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 rd_data zero", rd_data, 0);
        chk("R6 pio_err", pio_err, 1);
        chk("R7 irq on data-out read", irq, 1);
        chk("R6 count", count, 13);
        chk("R6 rd_ptr held", rd_ptr, 1);
        phase = 2'b10;
        for (int i = 0; i < 13; i++) begin
            step(1'b0, 8'h00, 1'b1, 1'b0);
            chk("R5 rd_data after data-out", rd_data, 8'hA1 + i);
            chk("R6 pio_err clear", pio_err, 0);
        end
        chk("R8 drained count", count, 0);
        chk("R8 drained ptrs", {rd_ptr, wr_ptr}, 0);

        // Empty read: R9
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R9 rd_data held", rd_data, 8'hAD);
        chk("R9 irq", irq, 0);
        chk("R9 ptrs", {rd_ptr, wr_ptr}, 0);
        chk("R9 count", count, 0);

        // Command capture: R4
        step(1'b1, 8'h55, 1'b0, 1'b0);
        cmd_mode = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 8'(8'hC0 + i), 1'b0, 1'b0);
            if (i == 2) begin
                chk("R4 cmd_len", cmd_len, 3);
                chk("R4 count unchanged", count, 1);
                chk("R4 wr_ptr unchanged", wr_ptr, 1);
            end
        end
        chk("R4 cmd_len saturates", cmd_len, 16);
        for (int i = 0; i < 16; i++) begin
            cmd_idx = 4'(i);
            #1;
            chk("R4 cmd_byte", cmd_byte, 8'hC0 + i);
        end
        cmd_mode = 1'b0;
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R4 queue byte kept", rd_data, 8'h55);

        // Flush overrides strobes: R10
        for (int i = 0; i < 5; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        cmd_mode = 1'b1;
        step(1'b1, 8'h99, 1'b0, 1'b0);
        cmd_mode = 1'b0;
        chk("R10 pre count", count, 5);
        step(1'b1, 8'h77, 1'b1, 1'b1);
        chk("R10 count", count, 0);
        chk("R10 ptrs", {rd_ptr, wr_ptr}, 0);
        chk("R10 cmd_len", cmd_len, 0);
        chk("R10 irq", irq, 0);
        chk("R10 rd_data", rd_data, 8'h55);

        // Concurrent read and write: R11
        step(1'b1, 8'h11, 1'b0, 1'b0);
        step(1'b1, 8'h22, 1'b0, 1'b0);
        step(1'b1, 8'h33, 1'b1, 1'b0);
        chk("R11 rd_data", rd_data, 8'h11);
        chk("R11 count", count, 2);
        chk("R11 rd_ptr", rd_ptr, 1);
        chk("R11 wr_ptr", wr_ptr, 3);
        chk("R11 irq", irq, 1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R11 second", rd_data, 8'h22);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R11 third", rd_data, 8'h33);
        step(1'b1, 8'h44, 1'b1, 1'b0);
        chk("R11 empty rd+wr count", count, 1);
        chk("R11 empty rd+wr irq", irq, 0);
        chk("R11 empty rd+wr rd_data", rd_data, 8'h33);
        chk("R11 empty rd+wr ptrs", {rd_ptr, wr_ptr}, 1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R11 late byte", rd_data, 8'h44);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule